// File: doc/BRIEF.md
# Instruction Memory Table-Access Port

This block holds a program store whose entries are 24 bits wide and presents it to software as a flat array of 16-bit words. Each stored instruction spans two consecutive word addresses. The even address carries the lower sixteen bits. The odd address carries the top eight bits, with a zero padding byte above them that has no storage behind it. A table port reads and writes through this word view, either as a full word or one byte lane at a time. Two fixed identification words sit at a high address and are set by parameters.

A second port serves instruction fetch. It keeps an even program counter that can be loaded or stepped by two. Every cycle it returns the whole 24-bit instruction at that counter. Both ports read the store before any write made in the same cycle, so a fetch or table read that meets a table write always sees the old contents.

Top module: `pmem_table_port`

## Requirements
- R1: While `rst_n` is low, `tbl_rdata`, `fetch_pc` and `fetch_instr` are all zero.
- R2: A table read at an even word address 2k returns bits [15:0] of instruction k on `tbl_rdata` one clock after `tbl_rd_en`. When `tbl_rd_en` is low, `tbl_rdata` keeps its previous value.
- R3: A table read at an odd word address 2k+1 returns instruction bits [23:16] in `tbl_rdata[7:0]`, and `tbl_rdata[15:8]` reads as 00h.
- R4: `tbl_byte_en[0]` selects the low byte lane [7:0] of the word and `tbl_byte_en[1]` selects the high lane [15:8]. A read returns zero in lanes that are not enabled. A write changes only the stored bits behind the enabled lanes.
- R5: A write to the high lane of an odd word address is discarded, and the stored instruction keeps all its bits.
- R6: A word address whose instruction index (address shifted right by one) is at or beyond `DEPTH` reads as zero, and writes there change no stored instruction. The device-ID words are the exception.
- R7: A read at FF0000h returns `DEVID_WORD_LO` and a read at FF0002h returns `DEVID_WORD_HI`, both subject to lane masking. Writes to these addresses have no effect. FF0001h reads as zero.
- R8: `fetch_pc` is always even. When `fetch_load` is high, it becomes `fetch_target` with bit 0 cleared; this takes priority over `fetch_advance`. Otherwise `fetch_advance` adds 2, modulo 2^24, and with neither input high the counter holds.
- R9: One clock after each edge, `fetch_instr` holds the 24-bit instruction at the `fetch_pc` value that was in place before that edge. It is zero when that instruction index is at or beyond `DEPTH`.
- R10: When a table write hits a location in the same cycle that a table read or a fetch reads it, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_rd_en | input | 1 | Table read request |
| tbl_wr_en | input | 1 | Table write request |
| tbl_byte_en | input | 2 | Byte lane enables: bit 0 low lane, bit 1 high lane |
| tbl_addr | input | 24 | Word address of the table access |
| tbl_wdata | input | 16 | Table write data |
| tbl_rdata | output | 16 | Registered table read data |
| fetch_load | input | 1 | Load the fetch counter from `fetch_target` |
| fetch_target | input | 24 | Jump address; bit 0 is ignored |
| fetch_advance | input | 1 | Step the fetch counter by 2 |
| fetch_pc | output | 24 | Current fetch program counter |
| fetch_instr | output | 24 | Registered instruction at the previous counter value |

## Verification
The hardest case to reach is a collision: a table write landing on the very instruction the fetch counter points at, or on the address the table port reads in the same cycle. To create it, the bench parks the counter with a load and then issues a write to that even address while it stays put. It also issues a combined read and write to a single address. Out-of-range writes use an index that folds onto entry zero if its upper bits were dropped, and the bench then reads entry zero back. Odd-address writes carry a nonzero high byte so that a store behind the padding byte would show up.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
    localparam int ADDR_W  = 24;
    localparam int WORD_W  = 16;
    localparam int INSTR_W = 24;

    localparam logic [ADDR_W-1:0] DEVID_ADDR_LO = 24'hFF0000;
    localparam logic [ADDR_W-1:0] DEVID_ADDR_HI = 24'hFF0002;

    typedef struct packed {
        logic [WORD_W-1:0]  rdata;
        logic [ADDR_W-1:0]  pc;
        logic [INSTR_W-1:0] finstr;
    } port_state_t;
endpackage

// File: rtl/pmem_addr_dec.sv
module pmem_addr_dec
    import pmem_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_mem,
    output logic [IDX_W-1:0]  idx,
    output logic              upper,
    output logic              id_lo,
    output logic              id_hi
);
    // word address -> instruction index and half select (R2, R3, R6, R7)
    always_comb begin
        in_mem = (addr >> 1) < ADDR_W'(DEPTH);
        idx    = IDX_W'(addr >> 1);
        upper  = addr[0];
        id_lo  = (addr == DEVID_ADDR_LO);
        id_hi  = (addr == DEVID_ADDR_HI);
    end
endmodule

// File: rtl/pmem_fetch_pc.sv
module pmem_fetch_pc
    import pmem_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic [ADDR_W-1:0] pc_q,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    input  logic              advance,
    output logic [ADDR_W-1:0] pc_d,
    output logic              in_range,
    output logic [IDX_W-1:0]  idx
);
    // R8: load wins, bit 0 of the target is dropped; advance steps by two
    always_comb begin
        if (load) begin
            pc_d = target & ~ADDR_W'(1);
        end else if (advance) begin
            pc_d = pc_q + ADDR_W'(2);
        end else begin
            pc_d = pc_q;
        end
        in_range = (pc_q >> 1) < ADDR_W'(DEPTH);
        idx      = IDX_W'(pc_q >> 1);
    end
endmodule

// File: rtl/pmem_store.sv
module pmem_store
    import pmem_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   w_idx,
    input  logic [2:0]         w_lane,
    input  logic [INSTR_W-1:0] w_data,
    input  logic [IDX_W-1:0]   ra_idx,
    output logic [INSTR_W-1:0] ra_data,
    input  logic [IDX_W-1:0]   rb_idx,
    output logic [INSTR_W-1:0] rb_data
);
    localparam int LANES = INSTR_W / 8;

    logic [INSTR_W-1:0] mem [DEPTH];

    // R4: per-lane write; reads are combinational and see pre-write contents (R10)
    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (w_lane[l]) begin
                    mem[w_idx][l*8 +: 8] <= w_data[l*8 +: 8];
                end
            end
        end
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
endmodule

// File: rtl/pmem_table_port.sv
module pmem_table_port
    import pmem_pkg::*;
#(
    parameter int          DEPTH         = 256,
    parameter logic [15:0] DEVID_WORD_LO = 16'h4D21,
    parameter logic [15:0] DEVID_WORD_HI = 16'h0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_rd_en,
    input  logic               tbl_wr_en,
    input  logic [1:0]         tbl_byte_en,
    input  logic [ADDR_W-1:0]  tbl_addr,
    input  logic [WORD_W-1:0]  tbl_wdata,
    output logic [WORD_W-1:0]  tbl_rdata,
    input  logic               fetch_load,
    input  logic [ADDR_W-1:0]  fetch_target,
    input  logic               fetch_advance,
    output logic [ADDR_W-1:0]  fetch_pc,
    output logic [INSTR_W-1:0] fetch_instr
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    port_state_t st_d, st_q;

    logic               t_in_mem, t_upper, t_id_lo, t_id_hi;
    logic [IDX_W-1:0]   t_idx;
    logic               f_in_range;
    logic [IDX_W-1:0]   f_idx;
    logic [ADDR_W-1:0]  pc_d;
    logic [INSTR_W-1:0] ra_data, rb_data;
    logic               st_we;
    logic [2:0]         st_lane;
    logic [INSTR_W-1:0] st_wdata;
    logic [WORD_W-1:0]  rd_word, rd_masked;

    pmem_addr_dec #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tbl_dec (
        .addr   (tbl_addr),
        .in_mem (t_in_mem),
        .idx    (t_idx),
        .upper  (t_upper),
        .id_lo  (t_id_lo),
        .id_hi  (t_id_hi)
    );

    pmem_fetch_pc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_fetch (
        .pc_q     (st_q.pc),
        .load     (fetch_load),
        .target   (fetch_target),
        .advance  (fetch_advance),
        .pc_d     (pc_d),
        .in_range (f_in_range),
        .idx      (f_idx)
    );

    pmem_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .we      (st_we),
        .w_idx   (t_idx),
        .w_lane  (st_lane),
        .w_data  (st_wdata),
        .ra_idx  (t_idx),
        .ra_data (ra_data),
        .rb_idx  (f_idx),
        .rb_data (rb_data)
    );

    // write steering: even -> bits [15:0], odd low lane -> bits [23:16],
    // odd high lane has no storage (R4, R5); out of range / ID ignored (R6, R7)
    always_comb begin
        st_we = tbl_wr_en && t_in_mem;
        if (t_upper) begin
            st_lane  = {tbl_byte_en[0], 2'b00};
            st_wdata = {tbl_wdata[7:0], 16'h0000};
        end else begin
            st_lane  = {1'b0, tbl_byte_en};
            st_wdata = {8'h00, tbl_wdata};
        end
    end

    // read word before lane masking (R2, R3, R6, R7)
    always_comb begin
        if (t_id_lo) begin
            rd_word = DEVID_WORD_LO;
        end else if (t_id_hi) begin
            rd_word = DEVID_WORD_HI;
        end else if (!t_in_mem) begin
            rd_word = '0;
        end else if (t_upper) begin
            rd_word = {8'h00, ra_data[23:16]};
        end else begin
            rd_word = ra_data[15:0];
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign rd_masked[g*8 +: 8] = tbl_byte_en[g] ? rd_word[g*8 +: 8] : 8'h00;
    end

    always_comb begin
        st_d        = st_q;
        st_d.pc     = pc_d;
        st_d.finstr = f_in_range ? rb_data : '0;
        if (tbl_rd_en) begin
            st_d.rdata = rd_masked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl_rdata   = st_q.rdata;
    assign fetch_pc    = st_q.pc;
    assign fetch_instr = st_q.finstr;
endmodule

// File: rtl/pmem_table_port_chk.sv
module pmem_table_port_chk
    import pmem_pkg::*;
#(
    parameter int          DEPTH         = 256,
    parameter logic [15:0] DEVID_WORD_LO = 16'h4D21,
    parameter logic [15:0] DEVID_WORD_HI = 16'h0003
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tbl_rd_en,
    input logic [1:0]         tbl_byte_en,
    input logic [ADDR_W-1:0]  tbl_addr,
    input logic [WORD_W-1:0]  tbl_rdata,
    input logic               fetch_load,
    input logic               fetch_advance,
    input logic [ADDR_W-1:0]  fetch_pc
);
    logic oor;
    assign oor = ((tbl_addr >> 1) >= ADDR_W'(DEPTH))
                 && (tbl_addr != DEVID_ADDR_LO) && (tbl_addr != DEVID_ADDR_HI);

    a_r8_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pc[0] == 1'b0);

    a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_load && fetch_advance) |=> fetch_pc == $past(fetch_pc) + ADDR_W'(2));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_load && !fetch_advance) |=> $stable(fetch_pc));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_rd_en |=> $stable(tbl_rdata));

    a_r3_odd_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en && tbl_addr[0]) |=> tbl_rdata[15:8] == 8'h00);

    a_r4_lane_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en && !tbl_byte_en[0]) |=> tbl_rdata[7:0] == 8'h00);

    a_r4_lane_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en && !tbl_byte_en[1]) |=> tbl_rdata[15:8] == 8'h00);

    a_r6_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en && oor) |=> tbl_rdata == '0);

    a_r7_devid_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en && tbl_addr == DEVID_ADDR_LO && tbl_byte_en == 2'b11)
        |=> tbl_rdata == DEVID_WORD_LO);

    a_r7_devid_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en && tbl_addr == DEVID_ADDR_HI && tbl_byte_en == 2'b11)
        |=> tbl_rdata == DEVID_WORD_HI);
endmodule

bind pmem_table_port pmem_table_port_chk #(
    .DEPTH         (DEPTH),
    .DEVID_WORD_LO (DEVID_WORD_LO),
    .DEVID_WORD_HI (DEVID_WORD_HI)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tbl_rd_en     (tbl_rd_en),
    .tbl_byte_en   (tbl_byte_en),
    .tbl_addr      (tbl_addr),
    .tbl_rdata     (tbl_rdata),
    .fetch_load    (fetch_load),
    .fetch_advance (fetch_advance),
    .fetch_pc      (fetch_pc)
);

// File: tb/tb_pmem_table_port.sv
module tb_pmem_table_port;
    localparam int          DEPTH = 16;
    localparam logic [15:0] ID_LO = 16'h4A13;
    localparam logic [15:0] ID_HI = 16'h0007;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  be = 2'b00;
    logic [23:0] addr = '0;
    logic [15:0] wd = '0;
    logic [15:0] tbl_rdata;
    logic        f_load = 1'b0, f_adv = 1'b0;
    logic [23:0] f_target = '0;
    logic [23:0] fetch_pc;
    logic [23:0] fetch_instr;

    always #2 clk = ~clk;

    pmem_table_port #(.DEPTH(DEPTH), .DEVID_WORD_LO(ID_LO), .DEVID_WORD_HI(ID_HI)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tbl_rd_en     (rd_en),
        .tbl_wr_en     (wr_en),
        .tbl_byte_en   (be),
        .tbl_addr      (addr),
        .tbl_wdata     (wd),
        .tbl_rdata     (tbl_rdata),
        .fetch_load    (f_load),
        .fetch_target  (f_target),
        .fetch_advance (f_adv),
        .fetch_pc      (fetch_pc),
        .fetch_instr   (fetch_instr)
    );

    // behavioural reference model
    logic [23:0] ref_mem [DEPTH];
    bit          vlo [DEPTH];
    bit          vhi [DEPTH];
    logic [15:0] e_rd = '0;
    logic [23:0] e_pc = '0;
    logic [23:0] e_fi = '0;
    bit          rd_ok = 1, fi_ok = 1;
    int          checks = 0, errors = 0;
    bit          done = 0;
    string       cur_req = "R1";

    function automatic logic [15:0] ref_read(logic [23:0] a, logic [1:0] b);
        logic [15:0] w;
        int k;
        k = int'(a >> 1);
        if (a == 24'hFF0000)      w = ID_LO;
        else if (a == 24'hFF0002) w = ID_HI;
        else if (k < DEPTH)       w = a[0] ? {8'h00, ref_mem[k][23:16]} : ref_mem[k][15:0];
        else                      w = 16'h0000;
        if (!b[0]) w[7:0]  = 8'h00;
        if (!b[1]) w[15:8] = 8'h00;
        return w;
    endfunction

    function automatic bit ref_known(logic [23:0] a);
        int k;
        k = int'(a >> 1);
        if (k < DEPTH) return a[0] ? vhi[k] : vlo[k];
        return 1;
    endfunction

    task automatic ref_write(logic [23:0] a, logic [1:0] b, logic [15:0] d);
        int k;
        k = int'(a >> 1);
        if (k < DEPTH) begin
            if (a[0]) begin
                if (b[0]) begin ref_mem[k][23:16] = d[7:0]; vhi[k] = 1; end
            end else begin
                if (b[0]) ref_mem[k][7:0]  = d[7:0];
                if (b[1]) ref_mem[k][15:8] = d[15:8];
                if (b == 2'b11) vlo[k] = 1;
            end
        end
    endtask

    task automatic check(string name, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    task automatic step();
        int k;
        if (!rst_n) begin
            e_rd = '0; e_pc = '0; e_fi = '0; rd_ok = 1; fi_ok = 1;
        end else begin
            k = int'(e_pc >> 1);
            if (k < DEPTH) begin e_fi = ref_mem[k]; fi_ok = vlo[k] && vhi[k]; end
            else begin e_fi = '0; fi_ok = 1; end
            if (rd_en) begin e_rd = ref_read(addr, be); rd_ok = ref_known(addr); end
            if (wr_en) ref_write(addr, be, wd);
            if (f_load)     e_pc = f_target & ~24'h1;
            else if (f_adv) e_pc = e_pc + 24'd2;
        end
        @(posedge clk);
        @(negedge clk);
        if (rd_ok) check("tbl_rdata", {8'h00, tbl_rdata}, {8'h00, e_rd});
        check("fetch_pc", fetch_pc, e_pc);
        if (fi_ok) check("fetch_instr", fetch_instr, e_fi);
    endtask

    task automatic acc(bit r, bit w, logic [23:0] a, logic [1:0] b, logic [15:0] d);
        rd_en = r; wr_en = w; addr = a; be = b; wd = d;
        step();
        rd_en = 0; wr_en = 0;
    endtask

    function automatic logic [23:0] pat(int i);
        return 24'hA5C30F ^ (24'(i) * 24'h010207);
    endfunction

    initial begin
        for (int i = 0; i < DEPTH; i++) begin vlo[i] = 0; vhi[i] = 0; ref_mem[i] = '0; end
        // R1: reset state
        cur_req = "R1";
        repeat (3) step();
        rst_n = 1'b1;

        // R4 full-word writes fill the store; R5 odd writes carry a junk high byte
        for (int i = 0; i < DEPTH; i++) begin
            cur_req = "R4"; acc(0, 1, 24'(2*i), 2'b11, pat(i)[15:0]);
            cur_req = "R5"; acc(0, 1, 24'(2*i+1), 2'b11, {8'h5A, pat(i)[23:16]});
        end
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) acc(1, 0, 24'(2*i), 2'b11, 16'h0);
        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) acc(1, 0, 24'(2*i+1), 2'b11, 16'h0);
        // R2: output holds with reads disabled
        cur_req = "R2";
        acc(0, 0, 24'd4, 2'b11, 16'h0);
        acc(0, 0, 24'd9, 2'b01, 16'h0);

        // R4: lane reads and lane writes
        cur_req = "R4";
        acc(1, 0, 24'd6, 2'b01, 16'h0);
        acc(1, 0, 24'd6, 2'b10, 16'h0);
        acc(1, 0, 24'd7, 2'b10, 16'h0);
        acc(1, 0, 24'd7, 2'b00, 16'h0);
        acc(0, 1, 24'd6, 2'b10, 16'hBEEF);
        acc(1, 0, 24'd6, 2'b11, 16'h0);
        acc(0, 1, 24'd9, 2'b01, 16'h77C3);
        acc(1, 0, 24'd9, 2'b11, 16'h0);
        acc(1, 0, 24'd8, 2'b11, 16'h0);

        // R5: high lane of odd word is discarded
        cur_req = "R5";
        acc(0, 1, 24'd11, 2'b10, 16'hFF00);
        acc(1, 0, 24'd11, 2'b11, 16'h0);
        acc(1, 0, 24'd10, 2'b11, 16'h0);

        // R6: out of range
        cur_req = "R6";
        acc(0, 1, 24'(2*DEPTH), 2'b11, 16'h1234);
        acc(0, 1, 24'(2*DEPTH+1), 2'b11, 16'h0099);
        acc(1, 0, 24'(2*DEPTH), 2'b11, 16'h0);
        acc(1, 0, 24'h7FFFFE, 2'b11, 16'h0);
        acc(1, 0, 24'h123457, 2'b11, 16'h0);
        acc(1, 0, 24'd0, 2'b11, 16'h0);
        acc(1, 0, 24'd1, 2'b11, 16'h0);

        // R7: device ID words
        cur_req = "R7";
        acc(1, 0, 24'hFF0000, 2'b11, 16'h0);
        acc(1, 0, 24'hFF0002, 2'b11, 16'h0);
        acc(1, 0, 24'hFF0001, 2'b11, 16'h0);
        acc(1, 0, 24'hFF0002, 2'b01, 16'h0);
        acc(0, 1, 24'hFF0000, 2'b11, 16'h0000);
        acc(1, 0, 24'hFF0000, 2'b11, 16'h0);

        // R8: load with odd target, then advance
        cur_req = "R8";
        f_load = 1; f_target = 24'h000005; step(); f_load = 0;
        f_adv = 1;
        cur_req = "R9";
        repeat (18) step();
        cur_req = "R8";
        f_load = 1; f_target = 24'h00000B; step(); f_load = 0; f_adv = 0;
        step();
        cur_req = "R9";
        step();

        // R10: write to the fetched location and to the read location in the same cycle
        cur_req = "R10";
        acc(0, 1, 24'd10, 2'b11, 16'h0F0F);
        step();
        acc(1, 1, 24'd12, 2'b11, 16'hC0DE);
        acc(1, 0, 24'd12, 2'b11, 16'h0);
        acc(1, 1, 24'd13, 2'b01, 16'h00AB);
        acc(1, 0, 24'd13, 2'b11, 16'h0);
        f_load = 1; f_target = 24'h00000C; step(); f_load = 0;
        step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule